// File: doc/BRIEF.md
# AES Round-Key Expander (128/192/256-bit keys)

This block turns an AES master key of 128, 192 or 256 bits into the full series of 128-bit round keys that a cipher core needs. The key length is chosen at run time with a two-bit code that is sampled with the start pulse. After start, the block works out one 32-bit key word per cycle from a sliding window of the most recent Nk words. Every fourth word completes a round key, which is presented on a valid/ready output stream.

The round keys leave in ascending order, from round key 0 (the master key words) to round key Nr. A final-key flag marks the last beat. The word S-box used for the substitution step and the round constants are both produced inside the block. When the consumer holds ready low, generation pauses with no loss. The block makes encryption-order keys only.

Top module: `aes_key_expander`

## Requirements
- R1: keySize 0, 1 and 2 select Nk = 4, 6 and 8 words. After one accepted start the block emits exactly 11, 13 or 15 beats and then keeps outValid low.
- R2: The master key is left-justified in masterKey: word W[j] is masterKey[255-32j -: 32], and bits not used by the selected length are ignored. Round key i carries words 4i..4i+3, with W[4i] in outKey[127:96], so round key 0 is the first four key words.
- R3: For i >= Nk, W[i] = W[i-Nk] XOR t. When i mod Nk = 0, t is W[i-1] rotated left by one byte, passed byte-wise through the AES S-box and XORed with the round constant. Otherwise t = W[i-1]. The final round key matches the published AES test vectors for all three lengths.
- R4: With Nk = 8, and only then, t is the S-box image of W[i-1] without rotation when i mod 8 = 4.
- R5: The round constant occupies the top byte of t. It starts at 0x01 and is doubled in GF(2^8) (reduction by 0x1B) after each use, whatever the key length.
- R6: While outValid is high and outReady is low, outValid, outKey and outLast hold their values.
- R7: outLast is high on the beat that carries round key Nr and on no other beat. After that beat is accepted, outValid falls.
- R8: A start is ignored while an expansion is running or a beat is still waiting, and a start with keySize code 3 is ignored. Neither changes the keys being emitted.
- R9: After reset, outValid and outLast are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an expansion; samples masterKey and keySize |
| keySize | input | 2 | 0: 128-bit, 1: 192-bit, 2: 256-bit, 3: reserved |
| masterKey | input | 256 | Master key, left-justified |
| outReady | input | 1 | Consumer accepts the current beat |
| outValid | output | 1 | outKey holds a round key |
| outKey | output | 128 | Round key, first word in the top bits |
| outLast | output | 1 | Marks round key Nr |

## Verification
The assertions assume that outReady is a plain level the consumer may hold low for any number of cycles. They also assume that start may arrive at any time, including mid-run and with the reserved code, because the block itself filters it. The stimulus keeps to this. It varies ready in a repeating stall pattern, injects a conflicting start in the middle of a run, and issues a reserved-code start. Key inputs are free 256-bit values, with junk in the unused low bits, so the ignored bits are exercised as well.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  localparam int WORD_W = 32;
  localparam int MAX_NK = 8;
  localparam int KEY_W  = WORD_W * MAX_NK;
  localparam int BLK_W  = 4 * WORD_W;
  localparam int IDX_W  = 6;
  localparam int PH_W   = 3;

  typedef struct packed {
    logic load;      // latch master key, reset constant
    logic step;      // produce one word this cycle
    logic fromKey;   // word comes straight from the master key
    logic rotSub;    // rotate + substitute + constant
    logic plainSub;  // substitute only (long keys)
    logic capture;   // fourth word of a round key
  } kx_strobe_t;

  function automatic logic [7:0] gfDouble(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] run;
    acc = 8'h00;
    run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = gfDouble(run);
    end
    return acc;
  endfunction

  // x^254 is the field inverse (0 maps to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] acc;
    logic [7:0] pw;
    acc = 8'h01;
    pw  = a;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      acc = gfMul(acc, pw);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sboxByte(input logic [7:0] a);
    logic [7:0] v;
    v = gfInv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_kx_subword.sv
module aes_kx_subword
  import aes_kx_pkg::*;
(
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] wordOut
);
  localparam int NBYTE = WORD_W / 8;

  for (genvar b = 0; b < NBYTE; b++) begin : gByte
    assign wordOut[8*b +: 8] = sboxByte(wordIn[8*b +: 8]);
  end
endmodule

// File: rtl/aes_kx_datapath.sv
module aes_kx_datapath
  import aes_kx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  kx_strobe_t        strb,
  input  logic [3:0]        nkWords,
  input  logic [KEY_W-1:0]  keyIn,
  output logic [BLK_W-1:0]  roundKey
);
  logic [KEY_W-1:0]  keyReg;
  logic [WORD_W-1:0] win [MAX_NK];
  logic [7:0]        rcon;
  logic [3*WORD_W-1:0] coll;
  logic [WORD_W-1:0] farWord, nearWord, subIn, subOut, temp, newWord;

  assign nearWord = win[0];

  always_comb begin
    case (nkWords)
      4'd6:    farWord = win[5];
      4'd8:    farWord = win[7];
      default: farWord = win[3];
    endcase
  end

  assign subIn = strb.rotSub ? {nearWord[WORD_W-9:0], nearWord[WORD_W-1 -: 8]} : nearWord;

  aes_kx_subword subword_i (
    .wordIn (subIn),
    .wordOut(subOut)
  );

  always_comb begin
    if (strb.rotSub)        temp = subOut ^ {rcon, {(WORD_W-8){1'b0}}};
    else if (strb.plainSub) temp = subOut;
    else                    temp = nearWord;
    newWord = strb.fromKey ? keyReg[KEY_W-1 -: WORD_W] : (farWord ^ temp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      rcon     <= 8'h01;
      coll     <= '0;
      roundKey <= '0;
      for (int j = 0; j < MAX_NK; j++) win[j] <= '0;
    end else begin
      if (strb.load) begin
        keyReg <= keyIn;
        rcon   <= 8'h01;
      end else if (strb.step) begin
        keyReg <= {keyReg[KEY_W-WORD_W-1:0], {WORD_W{1'b0}}};
        coll   <= {coll[2*WORD_W-1:0], newWord};
        win[0] <= newWord;
        for (int j = 1; j < MAX_NK; j++) win[j] <= win[j-1];
        if (strb.rotSub) rcon <= gfDouble(rcon);
        if (strb.capture) roundKey <= {coll, newWord};
      end
    end
  end

  AST_RCON_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rotSub |-> (rcon != 8'h00)); // R5
  AST_SUB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> $countones({strb.fromKey, strb.rotSub, strb.plainSub}) <= 1); // R4
endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl
  import aes_kx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] keySize,
  input  logic       outReady,
  output kx_strobe_t strb,
  output logic [3:0] nkWords,
  output logic       outValid,
  output logic       outLast
);
  logic             busy;
  logic [1:0]       sizeReg;
  logic [IDX_W-1:0] wordIdx, lastIdx;
  logic [PH_W-1:0]  phase;
  logic [1:0]       lane;
  logic             accept;

  always_comb begin
    case (sizeReg)
      2'd1:    nkWords = 4'd6;
      2'd2:    nkWords = 4'd8;
      default: nkWords = 4'd4;
    endcase
    lastIdx = {nkWords, 2'b00} + IDX_W'(27);  // 4*(Nk+6)+3
  end

  assign accept = start && !busy && !outValid && (keySize != 2'd3);

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.step     = busy && !(lane == 2'd3 && outValid && !outReady);
    strb.fromKey  = wordIdx < {2'b00, nkWords};
    strb.rotSub   = !strb.fromKey && (phase == '0);
    strb.plainSub = !strb.fromKey && (nkWords == 4'd8) && (phase == PH_W'(4));
    strb.capture  = strb.step && (lane == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sizeReg  <= 2'd0;
      wordIdx  <= '0;
      phase    <= '0;
      lane     <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        sizeReg <= keySize;
        wordIdx <= '0;
        phase   <= '0;
        lane    <= '0;
      end else if (strb.step) begin
        wordIdx <= wordIdx + 1'b1;
        lane    <= lane + 1'b1;
        phase   <= ({1'b0, phase} == nkWords - 4'd1) ? '0 : phase + 1'b1;
        if (wordIdx == lastIdx) busy <= 1'b0;
      end
      if (strb.capture) begin
        outValid <= 1'b1;
        outLast  <= (wordIdx == lastIdx);
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> wordIdx <= lastIdx); // R1
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> {1'b0, phase} < nkWords); // R3
  AST_LONG_ONLY_SUB: assert property (@(posedge clk) disable iff (!rstN)
    strb.plainSub |-> sizeReg == 2'd2); // R4
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander
  import aes_kx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       keySize,
  input  logic [KEY_W-1:0] masterKey,
  input  logic             outReady,
  output logic             outValid,
  output logic [BLK_W-1:0] outKey,
  output logic             outLast
);
  kx_strobe_t strb;
  logic [3:0] nkWords;

  aes_kx_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .keySize (keySize),
    .outReady(outReady),
    .strb    (strb),
    .nkWords (nkWords),
    .outValid(outValid),
    .outLast (outLast)
  );

  aes_kx_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .nkWords (nkWords),
    .keyIn   (masterKey),
    .roundKey(outKey)
  );

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKey) && $stable(outLast))); // R6
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && outReady) |=> !outValid); // R7
endmodule

// File: tb/aes_key_expander_tb_top.sv
`timescale 1ns/1ps
module aes_key_expander_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   keySize = 2'd0;
  logic [255:0] masterKey = '0;
  logic         outReady = 1'b0;
  logic         outValid;
  logic [127:0] outKey;
  logic         outLast;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  aes_key_expander dut_i (
    .clk(clk), .rstN(rstN), .start(start), .keySize(keySize),
    .masterKey(masterKey), .outReady(outReady),
    .outValid(outValid), .outKey(outKey), .outLast(outLast)
  );

  // vectors: key, size code, expected last round key, flags {checkLast, stall, inject}
  localparam int NV = 6;
  localparam logic [255:0] VK [NV] = '{
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hdeadbeef0badf00dcafef00d12345678},
    {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'hffffffffffffffff},
    256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
    256'h0,
    {128'hffffffffffffffffffffffffffffffff, 128'h0123456789abcdef0011223344556677},
    {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h55aa55aa55aa55aa}
  };
  localparam logic [1:0] VS [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1};
  localparam logic [127:0] VL [NV] = '{
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
    128'he98ba06f448c773c8ecc720401002202,
    128'hfe4890d1e6188d0b046df344706c631e,
    128'h0, 128'h0, 128'h0
  };
  localparam logic [2:0] VF [NV] = '{3'b100, 3'b110, 3'b101, 3'b010, 3'b010, 3'b001};

  logic [7:0]  sbT [256];
  logic [31:0] mw  [60];

  function automatic logic [7:0] polyMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  task automatic buildSbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      logic [7:0] s;
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (polyMul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int r = 0; r < 5; r++) s = s ^ ((inv << r) | (inv >> (8 - r)));
      sbT[x] = s;
    end
  endtask

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sbT[w[31:24]], sbT[w[23:16]], sbT[w[15:8]], sbT[w[7:0]]};
  endfunction

  task automatic buildModel(input logic [255:0] k, input logic [1:0] ks);
    int nk;
    logic [7:0] rc;
    logic [31:0] t;
    nk = (ks == 2'd0) ? 4 : (ks == 2'd1) ? 6 : 8;
    for (int i = 0; i < nk; i++) mw[i] = k[255 - 32*i -: 32];
    rc = 8'h01;
    for (int i = nk; i < 60; i++) begin
      t = mw[i-1];
      if (i % nk == 0) begin
        t = subW({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1B : 8'h00);
      end else if (nk == 8 && i % nk == 4) begin
        t = subW(t);
      end
      mw[i] = mw[i-nk] ^ t;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCase(input int v);
    logic [255:0] k;
    logic [1:0] ks;
    int nr, beat, cyc;
    bit held, injected;
    logic [127:0] heldKey, expKey;
    logic heldLast;
    k = VK[v]; ks = VS[v];
    nr = (ks == 2'd0) ? 10 : (ks == 2'd1) ? 12 : 14;
    buildModel(k, ks);
    @(negedge clk);
    start = 1'b1; keySize = ks; masterKey = k; outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    beat = 0; held = 0; injected = 0; heldKey = '0; heldLast = 1'b0;
    for (cyc = 0; cyc < 400 && beat <= nr; cyc++) begin
      start = 1'b0;
      if (VF[v][0] && beat == 2 && !injected) begin
        start = 1'b1; masterKey = ~k; keySize = (ks == 2'd0) ? 2'd2 : 2'd0;
        injected = 1;
      end
      outReady = VF[v][1] ? (cyc % 3 != 0) : 1'b1;
      if (outValid) begin
        if (held) chk(outKey == heldKey && outLast == heldLast, "R6 hold", outKey, heldKey);
        if (outReady) begin
          expKey = {mw[4*beat], mw[4*beat+1], mw[4*beat+2], mw[4*beat+3]};
          if (beat == 0) chk(outKey == expKey, "R2 key words", outKey, expKey);
          else if (ks == 2'd2) chk(outKey == expKey, VF[v][0] ? "R8/R4 round key" : "R4 round key", outKey, expKey);
          else chk(outKey == expKey, "R3/R5 round key", outKey, expKey);
          if (v == 0 && beat == 1)
            chk(outKey == 128'ha0fafe1788542cb123a339392a6c7605, "R5 first constant", outKey,
                128'ha0fafe1788542cb123a339392a6c7605);
          chk(outLast == (beat == nr), "R7 last flag", 128'(outLast), 128'(beat == nr));
          if (beat == nr && VF[v][2])
            chk(outKey == VL[v], "R3 published vector", outKey, VL[v]);
          beat++;
          held = 0;
        end else begin
          held = 1; heldKey = outKey; heldLast = outLast;
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(beat == nr + 1, "R1 beat count", 128'(beat), 128'(nr + 1));
    outReady = 1'b1;
    beat = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (outValid) beat++;
    end
    chk(beat == 0, "R1 quiet after last", 128'(beat), 128'(0));
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int seen;
    buildSbox();
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && outLast == 1'b0, "R9 reset state", {outValid, outLast}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R9 idle after reset", 128'(outValid), 0);
    for (int v = 0; v < NV; v++) runCase(v);
    // reserved size code is ignored
    @(negedge clk);
    start = 1'b1; keySize = 2'd3; masterKey = VK[0]; outReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, "R8 reserved code", 128'(seen), 0);
    // block still usable afterwards
    runCase(0);
    finished = 1;
    report();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule